// File: doc/BRIEF.md
# Power Button Press Classifier

This block watches an active-low push button and decides, for every press, whether it was a short tap or a long hold. The raw pin is first brought into the clock domain, then filtered by a debounce stage whose hold-off time is set by a 4-bit code in steps of five 1 ms ticks. The filter can be switched off. Each accepted press is timed against a long-press limit set by an 8-bit code in steps of one hundred ticks.

A press released before the limit sets a sticky short-press flag. Software clears the flag by writing 1 through a strobe. A hold that reaches the limit fires a single-cycle long-press pulse, and its release is not also counted as short. While the surrounding power logic reports that it is waiting on a delayed or timed power-up, the start of any accepted press fires a single-cycle wake-now pulse so the power-up can start early. When the function is disabled, no flag is set and no pulse is emitted.

Top module: `pwrkey_classifier`

## Requirements
- R1: With debounce enabled and code N, a change of the synchronized button level is accepted only after it has persisted for 5×(N+1) consecutive ms ticks. A shorter change is ignored. The accepted level only changes in a cycle that carries a tick.
- R2: With debounce disabled, a button level that is held for a few clock cycles is accepted without waiting for any tick.
- R3: A press held for 100×(L+1) ms ticks, where L is the long-press code, produces exactly one long_pulse of one clock cycle. A press released before that produces no long_pulse.
- R4: A press released before the long-press limit sets short_flag. short_flag stays set until it is cleared. Releasing a press that already produced a long_pulse does not set short_flag.
- R5: A cycle with clr_wr=1 and clr_data=1 clears short_flag. A write with clr_data=0 has no effect on short_flag, and a clearing write while short_flag is already 0 leaves it at 0.
- R6: While func_en=0, presses set no flag and produce no long_pulse and no wake_pulse.
- R7: The start of an accepted press while wake_wait=1 produces exactly one wake_pulse of one clock cycle. With wake_wait=0, no wake_pulse is produced.
- R8: After reset, short_flag, long_pulse and wake_pulse are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n_raw | input | 1 | Raw button pin, low while pressed, asynchronous |
| ms_tick | input | 1 | One-cycle pulse every 1 ms |
| func_en | input | 1 | Button function enable |
| deb_en | input | 1 | 1 = debounce filter active, 0 = bypass |
| deb_code | input | 4 | Debounce time code N, 5×(N+1) ticks |
| lp_code | input | 8 | Long-press code L, 100×(L+1) ticks |
| wake_wait | input | 1 | Power logic is waiting on a delayed or timed power-up |
| clr_wr | input | 1 | Write strobe for the short-press flag |
| clr_data | input | 1 | Write data, 1 clears the flag |
| short_flag | output | 1 | Sticky short-press flag |
| long_pulse | output | 1 | One-cycle long-press event |
| wake_pulse | output | 1 | One-cycle early power-up request |

## Verification
The most likely internal fault is a debounce or hold counter that reloads at the wrong moment or compares against an off-by-one limit. Such a fault appears at the ports within one press. A long_pulse arrives a step early or late, or a press near the limit lands in the wrong class and shows up as a wrong short_flag after release. A stuck tracking bit after a long press would set short_flag on the release. A filter that leaks glitches gives a spurious wake_pulse within four clock cycles of the glitch.

// File: rtl/pk_pkg.sv
package pk_pkg;
  // code widths seen at the configuration inputs
  localparam int unsigned DEB_CODE_W = 4;
  localparam int unsigned LP_CODE_W  = 8;

  // classifier state for one accepted press
  typedef struct packed {
    logic held;       // a press is in progress
    logic long_done;  // the long event already fired for this press
  } press_st_t;
endpackage

// File: rtl/pk_sync.sv
module pk_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        RST_LVL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_LVL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pk_debounce.sv
module pk_debounce
  import pk_pkg::*;
#(
  parameter int unsigned STEP_TICKS = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lvl_in,
  input  logic                  tick,
  input  logic                  deb_en,
  input  logic [DEB_CODE_W-1:0] deb_code,
  output logic                  lvl_out
);
  localparam int unsigned MAX_TICKS = STEP_TICKS * (1 << DEB_CODE_W);
  localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = (CW'(deb_code) + CW'(1)) * CW'(STEP_TICKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_out <= 1'b0;
      cnt_q   <= '0;
    end else if (!deb_en) begin
      lvl_out <= lvl_in;
      cnt_q   <= '0;
    end else if (lvl_in == lvl_out) begin
      cnt_q   <= '0;
    end else if (tick) begin
      if (cnt_q == lim - CW'(1)) begin
        lvl_out <= lvl_in;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + CW'(1);
      end
    end
  end

  AST_DEB_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
    (deb_en && !tick) |=> $stable(lvl_out)); // R1
endmodule

// File: rtl/pk_classify.sv
module pk_classify
  import pk_pkg::*;
#(
  parameter int unsigned STEP_TICKS = 100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pressed,
  input  logic                 tick,
  input  logic                 func_en,
  input  logic [LP_CODE_W-1:0] lp_code,
  input  logic                 wake_wait,
  input  logic                 clr_wr,
  input  logic                 clr_data,
  output logic                 short_flag,
  output logic                 long_pulse,
  output logic                 wake_pulse
);
  localparam int unsigned MAX_TICKS = STEP_TICKS * (1 << LP_CODE_W);
  localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

  press_st_t     st_q;
  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          press_edge;
  logic          release_ev;
  logic          set_short;

  assign lim        = (CW'(lp_code) + CW'(1)) * CW'(STEP_TICKS);
  assign press_edge = func_en && pressed && !prev_q;
  assign release_ev = func_en && st_q.held && !pressed;
  assign set_short  = release_ev && !st_q.long_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= '0;
      prev_q     <= 1'b0;
      cnt_q      <= '0;
      long_pulse <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      prev_q     <= pressed;
      long_pulse <= 1'b0;
      wake_pulse <= 1'b0;
      if (!func_en) begin
        st_q  <= '0;
        cnt_q <= '0;
      end else if (press_edge) begin
        st_q.held      <= 1'b1;
        st_q.long_done <= 1'b0;
        cnt_q          <= '0;
        wake_pulse     <= wake_wait;
      end else if (release_ev) begin
        st_q.held      <= 1'b0;
      end else if (st_q.held && tick && !st_q.long_done) begin
        if (cnt_q == lim - CW'(1)) begin
          long_pulse     <= 1'b1;
          st_q.long_done <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      short_flag <= 1'b0;
    else if (set_short)           short_flag <= 1'b1;
    else if (clr_wr && clr_data)  short_flag <= 1'b0;
  end

  AST_LONG_SINGLE: assert property (@(posedge clk) disable iff (rst)
    long_pulse |=> !long_pulse); // R3
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !func_en |=> (!long_pulse && !wake_pulse)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (short_flag && !clr_wr) |=> short_flag); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_data && !func_en) |=> !short_flag); // R5
endmodule

// File: rtl/pwrkey_classifier.sv
module pwrkey_classifier
  import pk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_STEP    = 5,
  parameter int unsigned LP_STEP     = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn_n_raw,
  input  logic       ms_tick,
  input  logic       func_en,
  input  logic       deb_en,
  input  logic [3:0] deb_code,
  input  logic [7:0] lp_code,
  input  logic       wake_wait,
  input  logic       clr_wr,
  input  logic       clr_data,
  output logic       short_flag,
  output logic       long_pulse,
  output logic       wake_pulse
);
  logic btn_n_sync;
  logic pressed;

  pk_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) sync_i (
    .clk(clk), .rst(rst), .d_async(btn_n_raw), .q_sync(btn_n_sync)
  );

  pk_debounce #(.STEP_TICKS(DEB_STEP)) deb_i (
    .clk(clk), .rst(rst), .lvl_in(!btn_n_sync), .tick(ms_tick),
    .deb_en(deb_en), .deb_code(deb_code), .lvl_out(pressed)
  );

  pk_classify #(.STEP_TICKS(LP_STEP)) cls_i (
    .clk(clk), .rst(rst), .pressed(pressed), .tick(ms_tick),
    .func_en(func_en), .lp_code(lp_code), .wake_wait(wake_wait),
    .clr_wr(clr_wr), .clr_data(clr_data), .short_flag(short_flag),
    .long_pulse(long_pulse), .wake_pulse(wake_pulse)
  );
endmodule

// File: tb/pwrkey_classifier_tb_top.sv
`timescale 1ns/100ps
module pwrkey_classifier_tb_top;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn_n_raw = 1'b1;
  logic       ms_tick = 1'b0;
  logic       func_en = 1'b1;
  logic       deb_en = 1'b1;
  logic [3:0] deb_code = 4'd0;
  logic [7:0] lp_code = 8'd0;
  logic       wake_wait = 1'b0;
  logic       clr_wr = 1'b0;
  logic       clr_data = 1'b0;
  logic       short_flag, long_pulse, wake_pulse;

  int tests = 0;
  int fails = 0;
  int long_cnt = 0;
  int wake_cnt = 0;
  int cyc = 0;
  int tdiv = 0;

  always #2.5 clk = ~clk;

  pwrkey_classifier dut_i (
    .clk(clk), .rst(rst), .btn_n_raw(btn_n_raw), .ms_tick(ms_tick),
    .func_en(func_en), .deb_en(deb_en), .deb_code(deb_code),
    .lp_code(lp_code), .wake_wait(wake_wait), .clr_wr(clr_wr),
    .clr_data(clr_data), .short_flag(short_flag),
    .long_pulse(long_pulse), .wake_pulse(wake_pulse)
  );

  // tick source and pulse monitors, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    ms_tick <= (tdiv == 0);
    if (long_pulse) long_cnt++;
    if (wake_pulse) wake_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic hold(input int ticks);
    btn_n_raw = 1'b0;
    wait_ticks(ticks);
    btn_n_raw = 1'b1;
  endtask

  task automatic clear_flag(input bit data);
    @(negedge clk); clr_wr = 1'b1; clr_data = data;
    @(negedge clk); clr_wr = 1'b0; clr_data = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(short_flag == 0 && long_pulse == 0 && wake_pulse == 0, "R8 reset",
          {short_flag, long_pulse, wake_pulse}, 0);
  endtask

  task automatic t_short_press;
    int l0;
    lp_code = 8'd2; deb_code = 4'd0; deb_en = 1'b1;
    l0 = long_cnt;
    hold(200); wait_ticks(20);
    check(short_flag == 1, "R4 short sets flag", short_flag, 1);
    check(long_cnt == l0, "R3 no long on short", long_cnt - l0, 0);
  endtask

  task automatic t_clear;
    clear_flag(1'b0);
    check(short_flag == 1, "R5 write 0 no effect", short_flag, 1);
    clear_flag(1'b1);
    check(short_flag == 0, "R5 write 1 clears", short_flag, 0);
    clear_flag(1'b1);
    check(short_flag == 0, "R5 write 1 on zero", short_flag, 0);
  endtask

  task automatic t_long_press;
    int l0;
    lp_code = 8'd2;
    l0 = long_cnt;
    btn_n_raw = 1'b0;
    wait_ticks(290);
    check(long_cnt == l0, "R3 no long before limit", long_cnt - l0, 0);
    wait_ticks(60);
    check(long_cnt == l0 + 1, "R3 one long at limit", long_cnt - l0, 1);
    wait_ticks(200);
    check(long_cnt == l0 + 1, "R3 still one long", long_cnt - l0, 1);
    btn_n_raw = 1'b1;
    wait_ticks(20);
    check(short_flag == 0, "R4 long release no short", short_flag, 0);
  endtask

  task automatic t_min_code;
    int l0;
    lp_code = 8'd0;
    l0 = long_cnt;
    hold(90); wait_ticks(20);
    check(long_cnt == l0, "R3 code0 below limit", long_cnt - l0, 0);
    check(short_flag == 1, "R4 code0 short", short_flag, 1);
    clear_flag(1'b1);
    hold(120); wait_ticks(20);
    check(long_cnt == l0 + 1, "R3 code0 long", long_cnt - l0, 1);
    check(short_flag == 0, "R4 code0 long no short", short_flag, 0);
  endtask

  task automatic t_debounce;
    int w0;
    deb_code = 4'd3; deb_en = 1'b1; wake_wait = 1'b1; lp_code = 8'd2;
    w0 = wake_cnt;
    hold(12); wait_ticks(30);
    check(wake_cnt == w0, "R1 glitch ignored", wake_cnt - w0, 0);
    check(short_flag == 0, "R1 glitch no flag", short_flag, 0);
    hold(40); wait_ticks(30);
    check(wake_cnt == w0 + 1, "R7 wake on press", wake_cnt - w0, 1);
    check(short_flag == 1, "R1 long enough accepted", short_flag, 1);
    clear_flag(1'b1);
    wake_wait = 1'b0;
  endtask

  task automatic t_bypass;
    int w0;
    deb_en = 1'b0; deb_code = 4'd15; wake_wait = 1'b1;
    w0 = wake_cnt;
    @(negedge clk); btn_n_raw = 1'b0;
    repeat (3) @(negedge clk);
    btn_n_raw = 1'b1;
    repeat (10) @(negedge clk);
    check(wake_cnt == w0 + 1, "R2 bypass accepts glitch", wake_cnt - w0, 1);
    check(short_flag == 1, "R2 bypass short", short_flag, 1);
    clear_flag(1'b1);
    wake_wait = 1'b0; deb_en = 1'b1; deb_code = 4'd3;
  endtask

  task automatic t_no_wake;
    int w0;
    wake_wait = 1'b0;
    w0 = wake_cnt;
    hold(40); wait_ticks(30);
    check(wake_cnt == w0, "R7 no wake when idle", wake_cnt - w0, 0);
    clear_flag(1'b1);
  endtask

  task automatic t_disabled;
    int w0, l0;
    func_en = 1'b0; wake_wait = 1'b1; lp_code = 8'd0;
    w0 = wake_cnt; l0 = long_cnt;
    hold(40); wait_ticks(30);
    check(short_flag == 0, "R6 no flag disabled", short_flag, 0);
    check(wake_cnt == w0, "R6 no wake disabled", wake_cnt - w0, 0);
    hold(150); wait_ticks(30);
    check(long_cnt == l0, "R6 no long disabled", long_cnt - l0, 0);
    func_en = 1'b1; wake_wait = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_short_press();
    t_clear();
    t_long_press();
    t_min_code();
    t_debounce();
    t_bypass();
    t_no_wake();
    t_disabled();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule